// File: doc/BRIEF.md
# Half-Bridge Interlock and Dead-Time Generator

This block sits between a PWM controller and the gate drivers of one half-bridge leg. It takes two active-high switch commands, one per side of the leg, and an active-low shutdown level that has already been qualified. It produces two gate-enable outputs and guarantees that the two switches are never on together.

A gate-enable output becomes active only when its own command is the only one asserted. That command must also have been held for a programmable number of clock cycles. This delay is the dead time, and it protects the leg even when the controller's own blanking is shorter than needed.

Turning a side off is never delayed: the output drops combinationally in the cycle its command drops. Asserting both commands together is treated as a fault, and so is asserting shutdown; in both cases the leg goes to tri-state with both outputs low. The dead time is the parameter `DT_CYCLES`, for example 60 cycles at 50 MHz for 1.2 µs.

Top module: `hb_deadtime_ctl`

## Requirements
- R1: While `shdn_n` is 0, `hi_gate` and `lo_gate` are both 0 for every value of `hi_cmd` and `lo_cmd`, with no cycle of delay.
- R2: While `hi_cmd` and `lo_cmd` are both 1, both outputs are 0 (interlock tri-state).
- R3: While `hi_cmd` and `lo_cmd` are both 0, both outputs are 0.
- R4: A single active command (`hi_cmd`=1 with `lo_cmd`=0, or the reverse) can only raise the gate of its own side; the other gate stays 0.
- R5: A gate rises when its command has been the sole active command at `DT_CYCLES` consecutive rising clock edges, and not before. It then stays high while that command stays the sole active one.
- R6: A gate falls in the same cycle its command falls, or its opposite command rises, or shutdown is asserted; turn-off is never delayed.
- R7: If a command is withdrawn before its dead time expires, the count restarts from zero on its next assertion.
- R8: With `DT_CYCLES` = 0 a sole command drives its gate in the same cycle, and the outputs still obey R1 to R4.
- R9: While `rst_n` is 0 both outputs are 0. After reset is released, the first turn-on waits the full dead time.
- R10: `hi_gate` and `lo_gate` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_cmd | input | 1 | High-side switch command, active high |
| lo_cmd | input | 1 | Low-side switch command, active high |
| shdn_n | input | 1 | Qualified shutdown level, active low |
| hi_gate | output | 1 | High-side gate enable |
| lo_gate | output | 1 | Low-side gate enable |

## Verification
The only internal state is the pair of dead-time counters. A counter that fails to clear shows up as a gate rising before `DT_CYCLES` edges. This is visible within a single dead-time window after a command is withdrawn and reapplied, or after shutdown or reset. A counter that stalls or overshoots shows up as a gate that stays low past edge `DT_CYCLES`. The combinational decode has no state, so a decode fault is visible at the ports in the same cycle as the offending input pattern.

// File: rtl/hb_leg_pkg.sv
// Shared types for the half-bridge dead-time controller.
// Assumes: nothing beyond IEEE 1800-2017.
package hb_leg_pkg;

    // Decoded state of the leg command inputs
    typedef enum logic [2:0] {
        LEG_IDLE  = 3'd0,   // no side requested
        LEG_HIGH  = 3'd1,   // high side alone requested
        LEG_LOW   = 3'd2,   // low side alone requested
        LEG_CLASH = 3'd3,   // both requested: interlock fault
        LEG_SAFE  = 3'd4    // shutdown or reset
    } leg_mode_e;

endpackage

// File: rtl/hb_cmd_decode.sv
// Decodes the two side commands, the shutdown level and the reset into a
// leg mode and one request per side.
// Assumes: shdn_n is already synchronous and qualified. The decode is purely
// combinational, so turn-off takes no cycle.
module hb_cmd_decode
    import hb_leg_pkg::*;
(
    input  logic      rst_n,
    input  logic      hi_cmd,
    input  logic      lo_cmd,
    input  logic      shdn_n,
    output leg_mode_e mode,
    output logic      hi_req,
    output logic      lo_req
);

    // Mode selection: shutdown and reset win over every command pattern
    always_comb begin
        if (!rst_n || !shdn_n) begin
            mode = LEG_SAFE;
        end else begin
            unique case ({hi_cmd, lo_cmd})
                2'b10:   mode = LEG_HIGH;
                2'b01:   mode = LEG_LOW;
                2'b11:   mode = LEG_CLASH;
                default: mode = LEG_IDLE;
            endcase
        end
    end

    // A side is requested only when it is the sole active command
    always_comb begin
        hi_req = (mode == LEG_HIGH);
        lo_req = (mode == LEG_LOW);
    end

endmodule

// File: rtl/hb_dt_timer.sv
// Dead-time qualifier for one side of the leg. The gate is raised once
// the request has been present at DT_CYCLES consecutive rising edges, and
// dropped at once when the request drops.
// Assumes: req is already exclusive with the opposite side's request.
module hb_dt_timer #(
    parameter int unsigned DT_CYCLES = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic gate
);

    generate
        if (DT_CYCLES == 0) begin : g_bypass
            // No dead time: the gate follows the exclusive request directly
            assign gate = req;

            // R8
            bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                gate == req);
        end else begin : g_count
            localparam int unsigned CNT_W = $clog2(DT_CYCLES + 1);
            localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DT_CYCLES);

            logic [CNT_W-1:0] cnt_q;
            logic             expired;

            assign expired = (cnt_q == CNT_END);

            // Count request-held edges, clear on withdrawal, saturate at the end
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!req) begin
                    cnt_q <= '0;
                end else if (!expired) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign gate = req & expired;

            // R7
            withdraw_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !req |=> !gate);

            // R6
            gate_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
                gate |-> req);
        end
    endgenerate

endmodule

// File: rtl/hb_deadtime_ctl.sv
// Half-bridge interlock and dead-time generator (top). Decodes the side
// commands and applies a per-side dead-time qualifier. The outputs are
// never driven high together.
// Assumes: synchronous active-low reset, qualified digital shutdown input.
module hb_deadtime_ctl
    import hb_leg_pkg::*;
#(
    parameter int unsigned DT_CYCLES = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic shdn_n,
    output logic hi_gate,
    output logic lo_gate
);

    leg_mode_e mode;
    logic      hi_req;
    logic      lo_req;

    hb_cmd_decode u_decode (
        .rst_n  (rst_n),
        .hi_cmd (hi_cmd),
        .lo_cmd (lo_cmd),
        .shdn_n (shdn_n),
        .mode   (mode),
        .hi_req (hi_req),
        .lo_req (lo_req)
    );

    hb_dt_timer #(.DT_CYCLES(DT_CYCLES)) u_hi_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (hi_req),
        .gate  (hi_gate)
    );

    hb_dt_timer #(.DT_CYCLES(DT_CYCLES)) u_lo_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (lo_req),
        .gate  (lo_gate)
    );

    // R1
    shdn_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |-> (!hi_gate && !lo_gate));

    // R2
    interlock_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cmd && lo_cmd) |-> (!hi_gate && !lo_gate));

    // R3
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LEG_IDLE) |-> (!hi_gate && !lo_gate));

    // R10
    no_overlap_chk: assert property (@(posedge clk)
        !(hi_gate && lo_gate));

    // R9
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_off_chk: assert (!hi_gate && !lo_gate);
        end
    end

    generate
        if (DT_CYCLES > 0) begin : g_gap_chk
            localparam int unsigned GAP_W = $clog2(DT_CYCLES + 1);
            localparam logic [GAP_W-1:0] GAP_END = GAP_W'(DT_CYCLES);

            logic [GAP_W-1:0] hi_gap_q;
            logic [GAP_W-1:0] lo_gap_q;

            // Edges since each gate was last seen high, saturating at the dead time
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hi_gap_q <= '0;
                    lo_gap_q <= '0;
                end else begin
                    hi_gap_q <= hi_gate ? '0 : ((hi_gap_q == GAP_END) ? hi_gap_q : hi_gap_q + 1'b1);
                    lo_gap_q <= lo_gate ? '0 : ((lo_gap_q == GAP_END) ? lo_gap_q : lo_gap_q + 1'b1);
                end
            end

            // R5
            hi_dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(hi_gate) |-> (lo_gap_q == GAP_END));

            // R5
            lo_dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(lo_gate) |-> (hi_gap_q == GAP_END));
        end
    endgenerate

endmodule

// File: tb/hb_deadtime_ctl_tb_top.sv
module hb_deadtime_ctl_tb_top;

    localparam int unsigned DT = 6;
    localparam int NVEC = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_cmd = 1'b0;
    logic lo_cmd = 1'b0;
    logic shdn_n = 1'b1;
    logic hi_gate, lo_gate, zh_gate, zl_gate;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hb_deadtime_ctl #(.DT_CYCLES(DT)) dut_i (
        .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
        .shdn_n(shdn_n), .hi_gate(hi_gate), .lo_gate(lo_gate));

    hb_deadtime_ctl #(.DT_CYCLES(0)) dut_z_i (
        .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
        .shdn_n(shdn_n), .hi_gate(zh_gate), .lo_gate(zl_gate));

    // {req_tag[3:0], shdn_n, hi, lo, wait_edges[7:0], exp_hi, exp_lo}
    localparam logic [16:0] VECS [NVEC] = '{
        {4'd3,  1'b1, 1'b0, 1'b0, 8'd8,  1'b0, 1'b0},  // R3 idle
        {4'd5,  1'b1, 1'b1, 1'b0, 8'd5,  1'b0, 1'b0},  // R5 high pending
        {4'd5,  1'b1, 1'b1, 1'b0, 8'd1,  1'b1, 1'b0},  // R5 high on at DT
        {4'd6,  1'b1, 1'b0, 1'b1, 8'd0,  1'b0, 1'b0},  // R6 swap: high off at once
        {4'd4,  1'b1, 1'b0, 1'b1, 8'd5,  1'b0, 1'b1},  // R4 low on after DT
        {4'd2,  1'b1, 1'b1, 1'b1, 8'd3,  1'b0, 1'b0},  // R2 clash
        {4'd5,  1'b1, 1'b0, 1'b1, 8'd5,  1'b0, 1'b0},  // R5 low pending
        {4'd3,  1'b1, 1'b0, 1'b0, 8'd1,  1'b0, 1'b0},  // R3 withdraw
        {4'd7,  1'b1, 1'b0, 1'b1, 8'd5,  1'b0, 1'b0},  // R7 count restarted
        {4'd7,  1'b1, 1'b0, 1'b1, 8'd1,  1'b0, 1'b1},  // R7 full DT after restart
        {4'd1,  1'b0, 1'b0, 1'b1, 8'd0,  1'b0, 1'b0},  // R1 shutdown immediate
        {4'd1,  1'b0, 1'b1, 1'b0, 8'd8,  1'b0, 1'b0},  // R1 shutdown held
        {4'd5,  1'b1, 1'b1, 1'b0, 8'd5,  1'b0, 1'b0},  // R5 pending after shutdown
        {4'd4,  1'b1, 1'b1, 1'b0, 8'd1,  1'b1, 1'b0},  // R4 high alone
        {4'd1,  1'b0, 1'b1, 1'b0, 8'd0,  1'b0, 1'b0},  // R1 shutdown drops high
        {4'd7,  1'b1, 1'b1, 1'b0, 8'd5,  1'b0, 1'b0},  // R7 restart after shutdown
        {4'd5,  1'b1, 1'b1, 1'b0, 8'd1,  1'b1, 1'b0},  // R5 on again
        {4'd5,  1'b1, 1'b1, 1'b0, 8'd20, 1'b1, 1'b0}   // R5 stays on
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        // R9: outputs held low in reset even with a command present
        hi_cmd = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset hi_gate", hi_gate, 1'b0);
        check("R9 reset lo_gate", lo_gate, 1'b0);
        check("R9 reset zero-dt hi_gate", zh_gate, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 zero-dt immediate hi_gate", zh_gate, 1'b1);
        repeat (DT - 1) @(posedge clk);
        #1;
        check("R9 first turn-on waits full DT", hi_gate, 1'b0);
        @(posedge clk);
        #1;
        check("R9 first turn-on at DT", hi_gate, 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            shdn_n = VECS[i][12];
            hi_cmd = VECS[i][11];
            lo_cmd = VECS[i][10];
            repeat (int'(VECS[i][9:2])) @(posedge clk);
            #1;
            check($sformatf("R%0d vec%0d hi_gate", VECS[i][16:13], i), hi_gate, VECS[i][1]);
            check($sformatf("R%0d vec%0d lo_gate", VECS[i][16:13], i), lo_gate, VECS[i][0]);
            // R8: zero dead time follows the exclusive decode directly
            check($sformatf("R8 vec%0d zero-dt hi_gate", i), zh_gate,
                  VECS[i][12] & VECS[i][11] & ~VECS[i][10]);
            check($sformatf("R8 vec%0d zero-dt lo_gate", i), zl_gate,
                  VECS[i][12] & ~VECS[i][11] & VECS[i][10]);
            // R10: never both on
            check($sformatf("R10 vec%0d overlap", i), hi_gate & lo_gate, 1'b0);
        end

        // R6: an active gate falls in the same cycle its command drops
        @(negedge clk);
        hi_cmd = 1'b0;
        #1;
        check("R6 immediate off on command drop", hi_gate, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule